// File: doc/BRIEF.md
# Resampling Step Factor Calculator

This block turns a pair of image sizes (source and destination, each with a width and a height) into the per-axis step values that an image scaler uses. A request carries all four dimensions on a valid/ready handshake. The block returns a 32-bit factor word, four mode flags and an error flag. The mode flags tell, per axis, whether the axis is enlarged or left at its size.

For each axis the step is a 16-bit fraction of 2^16. The formula depends on the direction of scaling. When the axis is enlarged, the step is the integer quotient of (src-1)·2^16 by (dst-1), reduced by one when that division leaves no remainder. When the axis is shrunk, the step is (dst-1)·2^16 divided by (src-1), plus one. An axis whose size does not change is marked as bypassed and its step is zero.

The two axes share one restoring divider, which produces one quotient bit per clock. The horizontal axis is computed first and the vertical axis second. A request that breaks the size or ratio limits yields an error, with a zero factor word and zero mode bits.

Top module: `scale_step_calc`

## Requirements
- R1: `in_ready` is high when the block is idle. It goes low in the cycle after a request is accepted and stays low until the result is presented. `out_valid` is a one-cycle pulse, and `in_ready` is high in that same cycle.
- R2: Mode bit encoding is mode[0] = horizontal bypass, mode[1] = horizontal up, mode[2] = vertical bypass, mode[3] = vertical up. This is the order of bits 20 to 23 of the scaler window control word. An axis is "up" when dst > src and "bypass" when dst == src.
- R3: Up-scaled axis: the step is floor(((src-1)<<16)/(dst-1)), minus 1 when the division is exact.
- R4: Down-scaled axis: the step is floor(((dst-1)<<16)/(src-1)) + 1, which is never zero.
- R5: A bypassed axis reports a step of zero.
- R6: The factor word carries the horizontal step in bits 15:0 and the vertical step in bits 31:16.
- R7: A request is in error if any dimension is below 128, any source dimension is above 8176, or any destination dimension is above 8128. On error, `err` is 1 and both `factor` and `mode` are 0.
- R8: A request is also in error if on either axis dst > 8·src or src > 8·dst. A ratio of exactly 8 is accepted.
- R9: `factor`, `mode` and `err` change only together with `out_valid`. They hold their values while inputs change with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| src_w | input | 13 | Source width |
| src_h | input | 13 | Source height |
| dst_w | input | 13 | Destination width |
| dst_h | input | 13 | Destination height |
| out_valid | output | 1 | One-cycle pulse when the result is presented |
| factor | output | 32 | Vertical step in 31:16, horizontal step in 15:0 |
| mode | output | 4 | {v_up, v_bypass, h_up, h_bypass} |
| err | output | 1 | Request broke a size or ratio limit |

## Verification
The assertions assume the requester follows the handshake: a request counts only in a cycle where both `in_valid` and `in_ready` are high. They also assume dimension inputs may change freely while the block is busy, because they are sampled only at acceptance.

The stimulus raises `in_valid` for exactly one accepted cycle and scrambles the dimension inputs between requests to exercise the hold behaviour. It draws random sizes mostly inside the 128..8176/8128 range with a ratio of at most 8. It adds deliberate out-of-range and over-ratio cases, together with directed exact-division, equal-size and ratio-boundary requests.

// File: rtl/scale_step_calc.sv
module scale_step_calc #(
  parameter int DIM_W     = 13,
  parameter int FRAC      = 16,
  parameter int DVD_W     = 33,
  parameter int MIN_DIM   = 128,
  parameter int MAX_SRC   = 8176,
  parameter int MAX_DST   = 8128,
  parameter int MAX_RATIO = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DIM_W-1:0]   src_w,
  input  logic [DIM_W-1:0]   src_h,
  input  logic [DIM_W-1:0]   dst_w,
  input  logic [DIM_W-1:0]   dst_h,
  output logic               out_valid,
  output logic [2*FRAC-1:0]  factor,
  output logic [3:0]         mode,
  output logic               err
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_DIV, S_FIX} st_t;
  st_t st;

  logic [DIM_W-1:0] sw_r, sh_r, dw_r, dh_r;
  logic             axis, err_r;
  logic [DVD_W-1:0] dvd;
  logic [DIM_W-1:0] rem;
  logic [FRAC-1:0]  q, fh;
  logic [1:0]       mh;
  logic [CNT_W-1:0] cnt;

  function automatic logic axis_bad(input logic [DIM_W-1:0] s, input logic [DIM_W-1:0] d);
    int si, di;
    si = int'(s);
    di = int'(d);
    return si < MIN_DIM || si > MAX_SRC || di < MIN_DIM || di > MAX_DST ||
           di > MAX_RATIO * si || si > MAX_RATIO * di;
  endfunction

  logic [DIM_W-1:0] cur_s, cur_d, num, den;
  logic             up, byp;
  assign cur_s = axis ? sh_r : sw_r;
  assign cur_d = axis ? dh_r : dw_r;
  assign up    = cur_d > cur_s;
  assign byp   = cur_d == cur_s;
  assign num   = (up ? cur_s : cur_d) - 1'b1;
  assign den   = (up ? cur_d : cur_s) - 1'b1;

  logic [DIM_W:0]  rem_sh;
  logic            ge;
  assign rem_sh = {rem, dvd[DVD_W-1]};
  assign ge     = rem_sh >= {1'b0, den};

  logic [FRAC-1:0] fix_val, ax_val;
  logic            ax_done;
  assign fix_val = up ? ((rem == '0) ? q - 1'b1 : q) : q + 1'b1;
  assign ax_done = (st == S_FIX) || (st == S_SETUP && (err_r || byp));
  assign ax_val  = (st == S_FIX) ? fix_val : '0;
  assign in_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sw_r <= '0; sh_r <= '0; dw_r <= '0; dh_r <= '0;
      axis <= 1'b0; err_r <= 1'b0;
      dvd <= '0; rem <= '0; q <= '0; cnt <= '0;
      fh <= '0; mh <= '0;
      out_valid <= 1'b0; factor <= '0; mode <= '0; err <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          sw_r <= src_w; sh_r <= src_h; dw_r <= dst_w; dh_r <= dst_h;
          err_r <= axis_bad(src_w, dst_w) || axis_bad(src_h, dst_h);
          axis <= 1'b0;
          st <= S_SETUP;
        end
        S_SETUP: if (!(err_r || byp)) begin
          dvd <= DVD_W'({num, {FRAC{1'b0}}});
          rem <= '0;
          q   <= '0;
          cnt <= CNT_W'(DVD_W);
          st  <= S_DIV;
        end
        S_DIV: begin
          rem <= DIM_W'(ge ? rem_sh - {1'b0, den} : rem_sh);
          q   <= {q[FRAC-2:0], ge};
          dvd <= dvd << 1;
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) st <= S_FIX;
        end
        default: ;
      endcase
      if (ax_done) begin
        if (!axis) begin
          fh   <= ax_val;
          mh   <= err_r ? 2'b00 : {up, byp};
          axis <= 1'b1;
          st   <= S_SETUP;
        end else begin
          factor    <= {ax_val, fh};
          mode      <= err_r ? 4'b0000 : {up, byp, mh};
          err       <= err_r;
          out_valid <= 1'b1;
          st        <= S_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/scale_step_calc_chk.sv
module scale_step_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic [31:0] factor,
  input logic [3:0]  mode,
  input logic        err
);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_ready_with_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_mode_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(mode[0] && mode[1]) && !(mode[2] && mode[3]));
  assert_down_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err && mode[1:0] == 2'b00) |-> factor[15:0] != 16'd0);
  assert_bypass_zero_h_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode[0]) |-> factor[15:0] == 16'd0);
  assert_bypass_zero_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode[2]) |-> factor[31:16] == 16'd0);
  assert_err_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err) |-> (factor == 32'd0 && mode == 4'd0));
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(factor) && $stable(mode) && $stable(err)));
endmodule

bind scale_step_calc scale_step_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .factor(factor), .mode(mode), .err(err)
);

// File: tb/scale_step_calc_tb.sv
module scale_step_calc_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_valid, err;
  logic [12:0] src_w, src_h, dst_w, dst_h;
  logic [31:0] factor;
  logic [3:0]  mode;

  scale_step_calc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .out_valid(out_valid), .factor(factor), .mode(mode), .err(err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] efac(input int s, input int d);
    longint n, dv, q;
    if (d == s) return 16'd0;
    if (d > s) begin
      n = longint'(s - 1) << 16; dv = d - 1; q = n / dv;
      if (n % dv == 0) q = q - 1;
    end else begin
      n = longint'(d - 1) << 16; dv = s - 1; q = n / dv + 1;
    end
    return q[15:0];
  endfunction

  function automatic bit ebad(input int s, input int d);
    return s < 128 || s > 8176 || d < 128 || d > 8128 || d > 8 * s || s > 8 * d;
  endfunction

  task automatic run(input int sw, input int sh, input int dw, input int dh, input string tag);
    logic [31:0] ef;
    logic [3:0]  em;
    bit          ee;
    int          n;
    ee = ebad(sw, dw) || ebad(sh, dh);
    if (ee) begin
      ef = 32'd0; em = 4'd0;
    end else begin
      ef = {efac(sh, dh), efac(sw, dw)};
      em = {dh > sh, dh == sh, dw > sw, dw == sw};
    end
    @(negedge clk);
    src_w = 13'(sw); src_h = 13'(sh); dst_w = 13'(dw); dst_h = 13'(dh);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R1 ready low after accept", 32'(in_ready), 32'd0);
    n = 0;
    while (!out_valid && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (!out_valid) begin
      chk(1'b0, "R1 result never presented", 32'd0, 32'd1);
    end else begin
      chk(in_ready, "R1 ready high with result", 32'(in_ready), 32'd1);
      chk(factor == ef, {tag, " factor R3 R4 R5 R6"}, factor, ef);
      chk(mode == em, {tag, " mode R2"}, 32'(mode), 32'(em));
      chk(err == ee, {tag, " err R7 R8"}, 32'(err), 32'(ee));
      @(negedge clk);
      chk(!out_valid, "R1 done is one pulse", 32'(out_valid), 32'd0);
      src_w = 13'($urandom); dst_h = 13'($urandom);
      repeat (3) @(negedge clk);
      chk(factor == ef && mode == em && err == ee, "R9 result held", factor, ef);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s, d, lo, hi;
    void'($urandom(32'd20260));
    rst_n = 1'b0; in_valid = 1'b0;
    src_w = '0; src_h = '0; dst_w = '0; dst_h = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && factor == 0 && mode == 0 && !err,
        "R1 reset state", {factor[27:0], mode}, 32'd0);

    run(128, 128, 256, 256, "R3 up non-exact");
    run(129, 129, 257, 257, "R3 up exact");
    run(256, 300, 128, 150, "R4 down");
    run(640, 480, 640, 720, "R5 h bypass");
    run(640, 480, 320, 480, "R5 v bypass R6");
    run(128, 1024, 1024, 128, "R8 ratio eight");
    run(128, 200, 1025, 200, "R8 ratio over up");
    run(300, 1025, 300, 128, "R8 ratio over down");
    run(127, 200, 200, 200, "R7 src below min");
    run(200, 200, 200, 127, "R7 dst below min");
    run(8177, 4000, 8000, 4000, "R7 src above max");
    run(4000, 4000, 4000, 8129, "R7 dst above max");
    run(8176, 8176, 8128, 8128, "R7 max sizes");

    for (int i = 0; i < 60; i++) begin
      int pw[2];
      int pd[2];
      for (int a = 0; a < 2; a++) begin
        s = 128 + int'($urandom % 8049);
        if ($urandom % 8 == 0) d = 100 + int'($urandom % 8200);
        else if ($urandom % 6 == 0) d = (s > 8128) ? 8128 : s;
        else begin
          lo = (s + 7) / 8; if (lo < 128) lo = 128;
          hi = 8 * s; if (hi > 8128) hi = 8128;
          d = lo + int'($urandom % (hi - lo + 1));
        end
        pw[a] = s; pd[a] = d;
      end
      run(pw[0], pw[1], pd[0], pd[1], "random R2 R3 R4 R8");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule